// File: doc/BRIEF.md
# Stretched-Event Clock-Domain Bridge

This block moves single-cycle event pulses from a source clock domain into a destination clock domain. The destination clock may run at the same rate as the source, a little faster or slower, or much slower. A one-cycle pulse sent directly across would be lost whenever the destination clock is not clearly faster than the source clock.

The bridge therefore works in three stages:
- **Source side.** Each accepted event is widened into a level that stays high for `STRETCH_LEN` source cycles. The level then stays low for a guard interval of the same length, so that the next event cannot fuse with it.
- **Destination side.** The level passes through a chain of synchronizer flops. The first flop is allowed to go metastable. The last flop is the trusted copy.
- **Reduction.** A rising-edge detector after the last flop turns each stretched level back into exactly one destination-cycle pulse.

While a level and its guard interval are in progress, the source side reports busy. An event that arrives during that time is not merged into the event in flight. It is rejected and reported on a one-cycle drop flag.

Choose `STRETCH_LEN` so that it is at least twice the worst-case destination period, divided by the shortest source period, plus one.

Top module: `pulse_bridge`

## Requirements
- R1: While `src_rst` is high, `src_busy` and `src_drop` are low at the next source edge. While `dst_rst` is high, `dst_pulse` is low at the next destination edge.
- R2: A `src_pulse` sampled while `src_busy` is low is accepted. `src_busy` is then high for exactly 2×`STRETCH_LEN` consecutive source cycles, starting with the cycle after the accepting edge.
- R3: Each accepted event produces exactly one `dst_pulse`, and that pulse is high for exactly one destination cycle. `dst_pulse` is never high in two consecutive destination cycles, even when the destination clock is faster than the source clock.
- R4: A `src_pulse` sampled while `src_busy` is high raises `src_drop` for the following source cycle only, and produces no `dst_pulse`. `src_drop` is low in every other cycle.
- R5: A `src_pulse` sampled in the first source cycle in which `src_busy` is low again is accepted as a new event.
- R6: The number of `dst_pulse` cycles equals the number of accepted events in each of these cases, with about ±0.5 ns of period jitter on both clocks:
  - equal clock periods;
  - destination clock slightly slower;
  - destination clock slightly faster;
  - destination clock about 1.75× slower;
  - destination clock about 2.25× slower;
  - destination clock about 2× faster.

  This holds when `STRETCH_LEN` meets the sizing rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_pulse | input | 1 | One-cycle event request in the source domain |
| src_busy | output | 1 | High while an event's stretch and guard interval are in progress |
| src_drop | output | 1 | One-cycle flag: an event arrived while busy and was rejected |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_pulse | output | 1 | One-cycle event in the destination domain, one per accepted event |

## Verification
Two functions can meet in the same source cycle: the end of the guard interval, which readies the stretcher, and the arrival of a new request, which either starts a new event or is dropped.

The bench provokes this by raising `src_pulse` on exactly the first cycle in which `src_busy` reads low. It expects acceptance with no drop flag, and later a second destination pulse. A second case raises a request two cycles into a stretch, and holds another request high for three cycles. Each must yield drop flags and no extra destination pulse.

Across the clock-ratio sweep with jitter, the events sent are compared one for one with the destination pulses counted, and no destination pulse may last two cycles.

// File: rtl/pulse_bridge_pkg.sv
package pulse_bridge_pkg;

  // Phases of the source-side stretcher
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_GAP  = 2'd2
  } stretch_phase_e;

  // Width of a down-counter that must hold n-1
  function automatic int cnt_bits(input int n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pb_stretch.sv
module pb_stretch
  import pulse_bridge_pkg::*;
#(
  parameter int STRETCH_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  output logic level_out,
  output logic busy_out,
  output logic drop_out
);

  localparam int CW = cnt_bits(STRETCH_LEN);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_LEN - 1);

  stretch_phase_e phase_q;
  logic [CW-1:0]  cnt_q;
  logic           level_q;
  logic           busy_q;
  logic           drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      level_q <= 1'b0;
      busy_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      // A request that finds the stretcher occupied is rejected, never merged
      drop_q <= evt_in && busy_q;
      case (phase_q)
        PH_IDLE: begin
          if (evt_in) begin
            phase_q <= PH_HOLD;
            cnt_q   <= LAST;
            level_q <= 1'b1;
            busy_q  <= 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            phase_q <= PH_GAP;
            cnt_q   <= LAST;
            level_q <= 1'b0;
          end
        end
        PH_GAP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          level_q <= 1'b0;
          busy_q  <= 1'b0;
        end
      endcase
    end
  end

  assign level_out = level_q;
  assign busy_out  = busy_q;
  assign drop_out  = drop_q;

endmodule

// File: rtl/pb_sync.sv
module pb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stg_q;

  // Stage 0 may go metastable; the last stage is the trusted copy
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[0] <= 1'b0;
        else     stg_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[i] <= 1'b0;
        else     stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/pb_edge.sv
module pb_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic pulse_out
);

  logic prev_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= level_in;
      pulse_q <= level_in && !prev_q;
    end
  end

  assign pulse_out = pulse_q;

endmodule

// File: rtl/pulse_bridge.sv
module pulse_bridge #(
  parameter int STRETCH_LEN = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  output logic src_busy,
  output logic src_drop,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);

  logic stretched;
  logic captured;

  pb_stretch #(.STRETCH_LEN(STRETCH_LEN)) u_stretch (
    .clk       (src_clk),
    .rst       (src_rst),
    .evt_in    (src_pulse),
    .level_out (stretched),
    .busy_out  (src_busy),
    .drop_out  (src_drop)
  );

  pb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (dst_clk),
    .rst      (dst_rst),
    .async_in (stretched),
    .sync_out (captured)
  );

  pb_edge u_edge (
    .clk       (dst_clk),
    .rst       (dst_rst),
    .level_in  (captured),
    .pulse_out (dst_pulse)
  );

endmodule

// File: rtl/pulse_bridge_chk.sv
module pulse_bridge_chk #(
  parameter int STRETCH_LEN = 4
) (
  input logic src_clk,
  input logic src_rst,
  input logic src_pulse,
  input logic src_busy,
  input logic src_drop,
  input logic dst_clk,
  input logic dst_rst,
  input logic dst_pulse
);

  localparam int RW = $clog2(2 * STRETCH_LEN + 2) + 1;
  localparam logic [RW-1:0] WINDOW = RW'(2 * STRETCH_LEN);

  logic [RW-1:0] run_q;

  // Length of the current busy run, checked against the window when it ends
  always_ff @(posedge src_clk) begin
    if (src_rst)       run_q <= '0;
    else if (src_busy) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_RESET_QUIET_SRC: assert property (@(posedge src_clk)
    src_rst |=> (!src_busy && !src_drop));                                     // R1
  AST_RESET_QUIET_DST: assert property (@(posedge dst_clk)
    dst_rst |=> !dst_pulse);                                                   // R1
  AST_ACCEPT_BUSY: assert property (@(posedge src_clk) disable iff (src_rst)
    (src_pulse && !src_busy) |=> src_busy);                                    // R2
  AST_BUSY_WINDOW: assert property (@(posedge src_clk) disable iff (src_rst)
    $fell(src_busy) |-> (run_q == WINDOW));                                    // R2
  AST_SINGLE_DST: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_pulse |=> !dst_pulse);                                                 // R3
  AST_DROP_FLAGGED: assert property (@(posedge src_clk) disable iff (src_rst)
    (src_pulse && src_busy) |=> src_drop);                                     // R4
  AST_DROP_ONLY_BUSY: assert property (@(posedge src_clk) disable iff (src_rst)
    !(src_pulse && src_busy) |=> !src_drop);                                   // R4

endmodule

bind pulse_bridge pulse_bridge_chk #(.STRETCH_LEN(STRETCH_LEN)) u_chk (
  .src_clk   (src_clk),
  .src_rst   (src_rst),
  .src_pulse (src_pulse),
  .src_busy  (src_busy),
  .src_drop  (src_drop),
  .dst_clk   (dst_clk),
  .dst_rst   (dst_rst),
  .dst_pulse (dst_pulse)
);

// File: tb/pulse_bridge_test.sv
`timescale 1ns/1ps
module pulse_bridge_test;

  localparam int L = 8;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst = 1'b1;
  logic dst_rst = 1'b1;
  logic src_pulse = 1'b0;
  logic src_busy, src_drop, dst_pulse;

  real src_per = 4.0;
  real dst_per = 4.0;
  bit  jitter  = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int dst_seen = 0;
  int drop_seen = 0;
  int dbl_seen = 0;
  bit dst_prev = 1'b0;
  bit done = 1'b0;

  pulse_bridge #(.STRETCH_LEN(L), .SYNC_STAGES(2)) uut (
    .src_clk(src_clk), .src_rst(src_rst), .src_pulse(src_pulse),
    .src_busy(src_busy), .src_drop(src_drop),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_pulse(dst_pulse)
  );

  function automatic real half(input real per);
    real j;
    j = jitter ? (real'($urandom_range(0, 500)) - 250.0) / 1000.0 : 0.0;
    return per / 2.0 + j;
  endfunction

  always begin #(half(src_per)); src_clk = ~src_clk; end
  initial begin
    #1.3;
    forever begin #(half(dst_per)); dst_clk = ~dst_clk; end
  end

  always @(negedge dst_clk) begin
    if (!dst_rst) begin
      if (dst_pulse) dst_seen++;
      if (dst_pulse && dst_prev) dbl_seen++;
      dst_prev = dst_pulse;
    end
  end

  always @(negedge src_clk) if (!src_rst && src_drop) drop_seen++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send();
    @(negedge src_clk) src_pulse = 1'b1;
    @(negedge src_clk) src_pulse = 1'b0;
  endtask

  task automatic drain();
    while (src_busy) @(negedge src_clk);
    repeat (12) @(negedge dst_clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge src_clk);
    chk(src_busy == 1'b0, "R1 busy in reset", int'(src_busy), 0);
    chk(src_drop == 1'b0, "R1 drop in reset", int'(src_drop), 0);
    @(negedge dst_clk);
    chk(dst_pulse == 1'b0, "R1 dst_pulse in reset", int'(dst_pulse), 0);
    @(negedge src_clk) src_rst = 1'b0;
    @(negedge dst_clk) dst_rst = 1'b0;
    repeat (4) @(negedge src_clk);
    chk(src_busy == 1'b0, "R1 busy after reset", int'(src_busy), 0);
  endtask

  task automatic t_window();
    int n = 0;
    int d0 = dst_seen;
    send();
    while (src_busy) begin n++; @(negedge src_clk); end
    chk(n == 2 * L, "R2 busy length", n, 2 * L);
    drain();
    chk(dst_seen - d0 == 1, "R3 one pulse per event", dst_seen - d0, 1);
    chk(dbl_seen == 0, "R3 pulse width", dbl_seen, 0);
  endtask

  task automatic t_drop();
    int d0 = dst_seen;
    int p0 = drop_seen;
    send();
    @(negedge src_clk) src_pulse = 1'b1;
    @(negedge src_clk) src_pulse = 1'b0;
    chk(src_drop == 1'b1, "R4 drop raised", int'(src_drop), 1);
    @(negedge src_clk);
    chk(src_drop == 1'b0, "R4 drop one cycle", int'(src_drop), 0);
    drain();
    chk(dst_seen - d0 == 1, "R4 dropped event not merged", dst_seen - d0, 1);
    chk(drop_seen - p0 == 1, "R4 drop count", drop_seen - p0, 1);
  endtask

  task automatic t_held();
    int d0 = dst_seen;
    int p0 = drop_seen;
    @(negedge src_clk) src_pulse = 1'b1;
    repeat (3) @(negedge src_clk);
    src_pulse = 1'b0;
    drain();
    chk(drop_seen - p0 == 2, "R4 held request drops", drop_seen - p0, 2);
    chk(dst_seen - d0 == 1, "R4 held request events", dst_seen - d0, 1);
  endtask

  task automatic t_boundary();
    int d0 = dst_seen;
    int p0 = drop_seen;
    send();
    while (src_busy) @(negedge src_clk);
    src_pulse = 1'b1;
    @(negedge src_clk) src_pulse = 1'b0;
    chk(src_busy == 1'b1, "R5 accepted at first idle", int'(src_busy), 1);
    chk(src_drop == 1'b0, "R5 no drop at first idle", int'(src_drop), 0);
    drain();
    chk(dst_seen - d0 == 2, "R5 both events delivered", dst_seen - d0, 2);
    chk(drop_seen - p0 == 0, "R5 no drops", drop_seen - p0, 0);
  endtask

  task automatic t_ratio(input real dper, input int n);
    int d0;
    int p0;
    int b0;
    dst_per = dper;
    jitter = 1'b1;
    repeat (20) @(negedge dst_clk);
    d0 = dst_seen; p0 = drop_seen; b0 = dbl_seen;
    for (int i = 0; i < n; i++) begin
      while (src_busy) @(negedge src_clk);
      repeat ($urandom_range(0, 2)) @(negedge src_clk);
      send();
    end
    drain();
    chk(dst_seen - d0 == n, $sformatf("R6 events out at dst %0.1f ns", dper), dst_seen - d0, n);
    chk(drop_seen - p0 == 0, "R6 no drops in sweep", drop_seen - p0, 0);
    chk(dbl_seen - b0 == 0, "R3 single-cycle pulses in sweep", dbl_seen - b0, 0);
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_window();
    t_drop();
    t_held();
    t_boundary();
    t_ratio(4.0, 40);
    t_ratio(4.3, 40);
    t_ratio(3.8, 40);
    t_ratio(7.0, 40);
    t_ratio(9.0, 40);
    t_ratio(2.0, 40);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule